// File: doc/BRIEF.md
# Banked Register Window with Packet-Buffer Pointer

This block is the host-facing register window of a packet interface. The host sees sixteen byte locations. Which registers sit behind most of them depends on a two-bit bank number, and the bank-select location itself is visible from every bank. In bank 2 a 16-bit pointer register selects a byte inside one of the packet buffers. Four window offsets then move packet bytes in and out of a 4 x 2048-byte buffer RAM. The pointer can advance by itself after each window access, so the host can stream a whole packet through the window.

Host accesses are 8, 16 or 32 bits wide. The block splits each access into byte operations at rising offsets and handles one byte per clock. It raises `host_ready` in the clock that handles the last byte. The host keeps `host_req` and its address, size and write data steady until it sees `host_ready`. In the cycle of that last byte, `host_rdata` holds the read result with byte i in bits [8i+7:8i]. The register behaviour here is limited to holding values. Buffer allocation happens elsewhere: the receive-queue head arrives as an input.

Top module: `banked_reg_window`

## Requirements
- R1: The block decodes only `host_addr[3:0]` and ignores all higher address bits.
- R2: Offset 14 is the bank register in every bank: a write stores data bits [1:0], and a read returns the bank zero-extended. Offset 15 always reads 0x33, and a write to offset 15 changes nothing. After reset the bank is 0.
- R3: One byte is handled per clock and `host_ready` is high in the clock of the last byte, so an 8-bit access completes in its first cycle. Sizes are 0 (8-bit), 1 (16-bit), 2 or 3 (32-bit). Byte i goes to offset (addr + i) mod 16 and uses data bits [8i+7:8i].
- R4: A 32-bit write at offset 12 skips bytes 0 and 1 and writes only offsets 14 and 15, taking two cycles.
- R5: These 16-bit registers reset to 0, and a byte write replaces only the half it addresses (even offset = low byte): bank 0 at 0/1 and 4/5; bank 1 at 0/1, 10/11 and 12/13. Bank 2 holds an 8-bit packet-number register at offset 2 and the pointer at 6/7.
- R6: A write to the low byte of the bank-1 control register at offset 12 clears data bits 0 and 1 before storing.
- R7: A read of the pointer high byte (bank 2, offset 7) returns it ANDed with 0xF7.
- R8: The bank-2 offsets 8..11 access the buffer RAM. Pointer bit 15 set selects the buffer named by `rx_head`. Clear selects the buffer named by the low bits of the packet-number register.
- R9: With pointer bit 14 clear, the byte address is (pointer[10:0] + offset[1:0]) mod 2048, and the pointer stays unchanged.
- R10: With pointer bit 14 set, every window byte access uses pointer[10:0] whatever the window offset. After the access, pointer[10:0] increments by one, wrapping in 11 bits, and pointer[15:11] is kept.
- R11: An offset with no register in the selected bank reads 0 and ignores writes. `bad_offset` is high in the cycle of each such byte access and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_req | input | 1 | Access request, held until `host_ready` |
| host_we | input | 1 | 1 = write, 0 = read |
| host_size | input | 2 | 0: 8-bit, 1: 16-bit, 2/3: 32-bit |
| host_addr | input | ADDR_W (8) | Byte address, bits [3:0] decoded |
| host_wdata | input | 32 | Write data, byte i in bits [8i+7:8i] |
| host_ready | output | 1 | Last byte of the access is handled this cycle |
| host_rdata | output | 32 | Read data, valid with `host_ready` on reads |
| rx_head | input | $clog2(NUM_BUF) (2) | Buffer at the head of the receive queue |
| bad_offset | output | 1 | Byte access to an undefined offset in this cycle |

## Verification
The hardest states to reach are those where a byte in the middle of one access changes how the following bytes decode. Two cases need this: a 16-bit write at offset 13 whose second byte switches the bank, and a 32-bit window access whose auto-incrementing pointer wraps from 0x7FF to 0 between bytes. The stimulus reaches them on purpose. It loads the pointer to 0x7FE with bit 14 set and streams a word through each of two different window offsets. It also issues wrapping accesses at offsets 12, 13 and 15. A behavioural per-byte model of banks, pointer and buffer bytes then predicts each cycle's result.

// File: rtl/bwin_pkg.sv
// Shared constants and types of the banked register window.
// Assumes byte-wide internal operations and a 16-bit buffer pointer.
package bwin_pkg;

    localparam logic [3:0] OFF_BANK    = 4'd14;
    localparam logic [3:0] OFF_ID      = 4'd15;
    localparam logic [7:0] ID_BYTE     = 8'h33;
    localparam logic [7:0] PTR_HI_MASK = 8'hF7;
    localparam logic [7:0] CTL_LO_MASK = 8'hFC;
    localparam int         PTR_RXQ_BIT = 15;
    localparam int         PTR_INC_BIT = 14;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_WIDE = 2'd3
    } acc_size_e;

    typedef struct packed {
        logic       valid;
        logic       we;
        logic [3:0] off;
        logic [7:0] wbyte;
    } byte_op_t;

endpackage

// File: rtl/bwin_byte_seq.sv
// Splits a host access of 1, 2 or 4 bytes into one byte operation per clock,
// at rising offsets that wrap at 16. It gathers read bytes into their lanes.
// Assumes the host holds request, size, offset and data until ready.
module bwin_byte_seq
    import bwin_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        host_req,
    input  logic        host_we,
    input  logic [1:0]  host_size,
    input  logic [3:0]  host_off,
    input  logic [31:0] host_wdata,
    input  logic [7:0]  byte_rdata,
    output logic        host_ready,
    output logic [31:0] host_rdata,
    output byte_op_t    op
);

    logic        mid_q;
    logic [1:0]  idx_q;
    logic [31:0] acc_q;
    logic [1:0]  last_i;
    logic [1:0]  first_i;
    logic [1:0]  cur_i;
    logic        is_last;
    logic        skip_lo;

    // Byte index of this cycle, and whether it is the last of the access.
    always_comb begin
        last_i     = host_size[1] ? 2'd3 : (host_size[0] ? 2'd1 : 2'd0);
        skip_lo    = host_we && host_size[1] && (host_off == 4'd12);
        first_i    = skip_lo ? 2'd2 : 2'd0;
        cur_i      = mid_q ? idx_q : first_i;
        is_last    = (cur_i == last_i);
        op.valid   = host_req;
        op.we      = host_we;
        op.off     = host_off + {2'b00, cur_i};
        op.wbyte   = host_wdata[{cur_i, 3'b000} +: 8];
        host_ready = host_req && is_last;
        host_rdata = acc_q | ({24'd0, byte_rdata} << {cur_i, 3'b000});
    end

    // Advance through the bytes and collect the read lanes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mid_q <= 1'b0;
            idx_q <= 2'd0;
            acc_q <= 32'd0;
        end else if (host_req) begin
            if (is_last) begin
                mid_q <= 1'b0;
                idx_q <= 2'd0;
                acc_q <= 32'd0;
            end else begin
                mid_q <= 1'b1;
                idx_q <= cur_i + 2'd1;
                acc_q[{cur_i, 3'b000} +: 8] <= byte_rdata;
            end
        end
    end

    assert_single_byte_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (host_req && !mid_q && host_size == SZ_BYTE) |-> host_ready)
        else $error("8-bit access did not complete in one cycle");

    assert_done_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
        host_ready |=> !mid_q)
        else $error("sequencer still mid-access after ready");

    assert_word12_skip_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (host_req && host_we && host_size[1] && host_off == 4'd12 && !mid_q)
            |-> (op.off == OFF_BANK && !host_ready))
        else $error("32-bit write at 12 did not start at offset 14");

endmodule

// File: rtl/bwin_buf_ram.sv
// Packet buffer storage: NUM_BUF buffers of BUF_BYTES bytes each, kept as
// 32-bit words with byte lanes. Reads are combinational and writes happen at
// the clock edge. Assumes BUF_BYTES is a power of two and at least 4.
module bwin_buf_ram #(
    parameter int NUM_BUF   = 4,
    parameter int BUF_BYTES = 2048,
    localparam int RAM_AW   = $clog2(NUM_BUF) + $clog2(BUF_BYTES),
    localparam int WORDS    = NUM_BUF * BUF_BYTES / 4
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [RAM_AW-1:0] addr,
    input  logic [7:0]        wbyte,
    output logic [7:0]        rbyte
);

    logic [31:0] mem [WORDS];
    logic [31:0] word;

    // Select the addressed byte lane of the addressed word.
    always_comb begin
        word  = mem[addr[RAM_AW-1:2]];
        rbyte = word[{addr[1:0], 3'b000} +: 8];
    end

    // Store one byte lane.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[addr[RAM_AW-1:2]][{addr[1:0], 3'b000} +: 8] <= wbyte;
        end
    end

endmodule

// File: rtl/bwin_regs.sv
// Decodes one byte operation against the selected bank. It holds the bank
// registers and the buffer pointer, and computes the buffer byte address of
// the data window. Assumes BUF_BYTES <= 16384, so pointer bits 15 and 14
// stay free for the queue-select and auto-increment flags.
module bwin_regs
    import bwin_pkg::*;
#(
    parameter int NUM_BUF   = 4,
    parameter int BUF_BYTES = 2048,
    localparam int SEL_W    = $clog2(NUM_BUF),
    localparam int BUF_AW   = $clog2(BUF_BYTES),
    localparam int RAM_AW   = SEL_W + BUF_AW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  byte_op_t          op,
    input  logic [SEL_W-1:0]  rx_head,
    input  logic [7:0]        mem_rbyte,
    output logic              mem_we,
    output logic [RAM_AW-1:0] mem_addr,
    output logic [7:0]        mem_wbyte,
    output logic [7:0]        rbyte,
    output logic              err
);

    logic [1:0]  bank_q;
    logic [15:0] txcfg_q, rxcfg_q, cfg_q, gp_q, ctl_q, ptr_q;
    logic [7:0]  pkt_q;

    logic sel_bank, sel_id, sel_tx, sel_rx, sel_cfg, sel_gp, sel_ctl;
    logic sel_pkt, sel_ptr, win_hit, defined, hi;
    logic [SEL_W-1:0]  win_buf;
    logic [BUF_AW-1:0] win_off;

    function automatic logic [7:0] half_of(input logic [15:0] v, input logic h);
        return h ? v[15:8] : v[7:0];
    endfunction

    function automatic logic [15:0] put_half(input logic [15:0] v, input logic h,
                                             input logic [7:0] b);
        return h ? {b, v[7:0]} : {v[15:8], b};
    endfunction

    // Which register, if any, the current offset names in the selected bank.
    always_comb begin
        hi       = op.off[0];
        sel_bank = (op.off == OFF_BANK);
        sel_id   = (op.off == OFF_ID);
        sel_tx   = 1'b0; sel_rx  = 1'b0; sel_cfg = 1'b0; sel_gp  = 1'b0;
        sel_ctl  = 1'b0; sel_pkt = 1'b0; sel_ptr = 1'b0; win_hit = 1'b0;
        if (!sel_bank && !sel_id) begin
            case (bank_q)
                2'd0: begin
                    sel_tx = (op.off[3:1] == 3'd0);
                    sel_rx = (op.off[3:1] == 3'd2);
                end
                2'd1: begin
                    sel_cfg = (op.off[3:1] == 3'd0);
                    sel_gp  = (op.off[3:1] == 3'd5);
                    sel_ctl = (op.off[3:1] == 3'd6);
                end
                2'd2: begin
                    sel_pkt = (op.off == 4'd2);
                    sel_ptr = (op.off[3:1] == 3'd3);
                    win_hit = (op.off[3:2] == 2'd2);
                end
                default: ;
            endcase
        end
        defined = sel_bank | sel_id | sel_tx | sel_rx | sel_cfg | sel_gp
                | sel_ctl | sel_pkt | sel_ptr | win_hit;
        err = op.valid && !defined;
    end

    // Buffer byte address of the data window.
    always_comb begin
        win_buf = ptr_q[PTR_RXQ_BIT] ? rx_head : pkt_q[SEL_W-1:0];
        if (ptr_q[PTR_INC_BIT]) begin
            win_off = ptr_q[BUF_AW-1:0];
        end else begin
            win_off = ptr_q[BUF_AW-1:0] + BUF_AW'(op.off[1:0]);
        end
        mem_addr  = {win_buf, win_off};
        mem_we    = op.valid && op.we && win_hit;
        mem_wbyte = op.wbyte;
    end

    // Read data multiplexer.
    always_comb begin
        rbyte = 8'h00;
        if (sel_bank)     rbyte = {6'd0, bank_q};
        else if (sel_id)  rbyte = ID_BYTE;
        else if (sel_tx)  rbyte = half_of(txcfg_q, hi);
        else if (sel_rx)  rbyte = half_of(rxcfg_q, hi);
        else if (sel_cfg) rbyte = half_of(cfg_q, hi);
        else if (sel_gp)  rbyte = half_of(gp_q, hi);
        else if (sel_ctl) rbyte = half_of(ctl_q, hi);
        else if (sel_pkt) rbyte = pkt_q;
        else if (sel_ptr) rbyte = hi ? (ptr_q[15:8] & PTR_HI_MASK) : ptr_q[7:0];
        else if (win_hit) rbyte = mem_rbyte;
    end

    // Register writes, and pointer auto-increment on window accesses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bank_q  <= 2'd0;
            txcfg_q <= 16'd0;
            rxcfg_q <= 16'd0;
            cfg_q   <= 16'd0;
            gp_q    <= 16'd0;
            ctl_q   <= 16'd0;
            pkt_q   <= 8'd0;
            ptr_q   <= 16'd0;
        end else if (op.valid) begin
            if (op.we) begin
                if (sel_bank) bank_q  <= op.wbyte[1:0];
                if (sel_tx)   txcfg_q <= put_half(txcfg_q, hi, op.wbyte);
                if (sel_rx)   rxcfg_q <= put_half(rxcfg_q, hi, op.wbyte);
                if (sel_cfg)  cfg_q   <= put_half(cfg_q, hi, op.wbyte);
                if (sel_gp)   gp_q    <= put_half(gp_q, hi, op.wbyte);
                if (sel_ctl)  ctl_q   <= put_half(ctl_q, hi,
                                          hi ? op.wbyte : (op.wbyte & CTL_LO_MASK));
                if (sel_pkt)  pkt_q   <= op.wbyte;
                if (sel_ptr)  ptr_q   <= put_half(ptr_q, hi, op.wbyte);
            end
            if (win_hit && ptr_q[PTR_INC_BIT]) begin
                ptr_q[BUF_AW-1:0] <= ptr_q[BUF_AW-1:0] + 1'b1;
            end
        end
    end

    assert_bank_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(op.valid && op.we && op.off == OFF_BANK) |=> $stable(bank_q))
        else $error("bank changed without a bank write");

    assert_ctl_low_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_q[1:0] == 2'b00)
        else $error("control register bits 1:0 set");

    assert_ptr_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (op.valid && win_hit && !ptr_q[PTR_INC_BIT]) |=> $stable(ptr_q))
        else $error("pointer moved without auto-increment");

    assert_autoinc_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (op.valid && win_hit && ptr_q[PTR_INC_BIT])
            |=> (ptr_q[BUF_AW-1:0] == $past(ptr_q[BUF_AW-1:0]) + 1'b1
                 && ptr_q[15:11] == $past(ptr_q[15:11])))
        else $error("auto-increment step wrong");

    assert_undef_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (op.valid && err) |=> ($stable(txcfg_q) && $stable(rxcfg_q) && $stable(cfg_q)
            && $stable(gp_q) && $stable(ctl_q) && $stable(pkt_q) && $stable(ptr_q)
            && $stable(bank_q)))
        else $error("undefined offset changed a register");

    always_comb begin
        assert_undef_nomem_R11: assert (!(err && mem_we))
            else $error("undefined offset wrote the buffer");
    end

endmodule

// File: rtl/banked_reg_window.sv
// Top of the banked register window: byte sequencer, bank register decode
// and packet buffer RAM. Only host_addr[3:0] is decoded.
module banked_reg_window
    import bwin_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int NUM_BUF   = 4,
    parameter int BUF_BYTES = 2048
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       host_req,
    input  logic                       host_we,
    input  logic [1:0]                 host_size,
    input  logic [ADDR_W-1:0]          host_addr,
    input  logic [31:0]                host_wdata,
    output logic                       host_ready,
    output logic [31:0]                host_rdata,
    input  logic [$clog2(NUM_BUF)-1:0] rx_head,
    output logic                       bad_offset
);

    localparam int RAM_AW = $clog2(NUM_BUF) + $clog2(BUF_BYTES);

    byte_op_t          op;
    logic [7:0]        reg_rbyte;
    logic [7:0]        ram_rbyte;
    logic [7:0]        ram_wbyte;
    logic              ram_we;
    logic [RAM_AW-1:0] ram_addr;
    logic              unused_addr_hi;

    // Upper address bits are not decoded.
    assign unused_addr_hi = ^host_addr[ADDR_W-1:4];

    bwin_byte_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_req   (host_req),
        .host_we    (host_we),
        .host_size  (host_size),
        .host_off   (host_addr[3:0]),
        .host_wdata (host_wdata),
        .byte_rdata (reg_rbyte),
        .host_ready (host_ready),
        .host_rdata (host_rdata),
        .op         (op)
    );

    bwin_regs #(.NUM_BUF(NUM_BUF), .BUF_BYTES(BUF_BYTES)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .op        (op),
        .rx_head   (rx_head),
        .mem_rbyte (ram_rbyte),
        .mem_we    (ram_we),
        .mem_addr  (ram_addr),
        .mem_wbyte (ram_wbyte),
        .rbyte     (reg_rbyte),
        .err       (bad_offset)
    );

    bwin_buf_ram #(.NUM_BUF(NUM_BUF), .BUF_BYTES(BUF_BYTES)) u_ram (
        .clk   (clk),
        .wr_en (ram_we),
        .addr  (ram_addr),
        .wbyte (ram_wbyte),
        .rbyte (ram_rbyte)
    );

endmodule

// File: tb/banked_reg_window_bench.sv
// Drives host accesses and compares every byte cycle against a behavioural
// model of banks, pointer and buffer bytes.
module banked_reg_window_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic        we = 1'b0;
    logic [1:0]  size = 2'd0;
    logic [7:0]  addr = 8'd0;
    logic [31:0] wdata = 32'd0;
    logic [1:0]  rx_head = 2'd0;
    logic        ready;
    logic [31:0] rdata;
    logic        bad;

    int checks = 0;
    int fails  = 0;

    int m_bank = 0, m_tx = 0, m_rx = 0, m_cfg = 0, m_gp = 0, m_ctl = 0;
    int m_pkt = 0, m_ptr = 0;
    int m_mem [int];

    always #5 clk = ~clk;

    banked_reg_window u_banked_reg_window (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_req   (req),
        .host_we    (we),
        .host_size  (size),
        .host_addr  (addr),
        .host_wdata (wdata),
        .host_ready (ready),
        .host_rdata (rdata),
        .rx_head    (rx_head),
        .bad_offset (bad)
    );

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual 0x%08h expected 0x%08h", tag, what, act, exp);
        end
    endtask

    function automatic int hf(input int v, input int off);
        return (off & 1) ? ((v >> 8) & 255) : (v & 255);
    endfunction

    function automatic int pt(input int v, input int off, input int b);
        return (off & 1) ? ((v & 'hff) | (b << 8)) : ((v & 'hff00) | b);
    endfunction

    // Behavioural effect of one byte operation on the model state.
    task automatic model_byte(input bit w, input int off, input int wb,
                              output int rb, output bit er);
        rb = 0;
        er = 0;
        if (off == 14) begin
            rb = m_bank;
            if (w) m_bank = wb & 3;
        end else if (off == 15) begin
            rb = 'h33;
        end else if (m_bank == 0 && off < 2) begin
            rb = hf(m_tx, off); if (w) m_tx = pt(m_tx, off, wb);
        end else if (m_bank == 0 && (off == 4 || off == 5)) begin
            rb = hf(m_rx, off); if (w) m_rx = pt(m_rx, off, wb);
        end else if (m_bank == 1 && off < 2) begin
            rb = hf(m_cfg, off); if (w) m_cfg = pt(m_cfg, off, wb);
        end else if (m_bank == 1 && (off == 10 || off == 11)) begin
            rb = hf(m_gp, off); if (w) m_gp = pt(m_gp, off, wb);
        end else if (m_bank == 1 && (off == 12 || off == 13)) begin
            rb = hf(m_ctl, off);
            if (w) m_ctl = pt(m_ctl, off, (off == 12) ? (wb & 'hfc) : wb);
        end else if (m_bank == 2 && off == 2) begin
            rb = m_pkt; if (w) m_pkt = wb;
        end else if (m_bank == 2 && off == 6) begin
            rb = hf(m_ptr, off); if (w) m_ptr = pt(m_ptr, off, wb);
        end else if (m_bank == 2 && off == 7) begin
            rb = hf(m_ptr, off) & 'hf7; if (w) m_ptr = pt(m_ptr, off, wb);
        end else if (m_bank == 2 && off >= 8 && off <= 11) begin
            int n, p, key;
            n = (m_ptr & 'h8000) ? int'(rx_head) : (m_pkt & 3);
            p = m_ptr & 'h7ff;
            if (m_ptr & 'h4000) m_ptr = (m_ptr & 'hf800) | ((m_ptr + 1) & 'h7ff);
            else p = (p + (off & 3)) & 'h7ff;
            key = n * 2048 + p;
            if (w) m_mem[key] = wb;
            else rb = m_mem.exists(key) ? m_mem[key] : 0;
        end else begin
            er = 1;
        end
    endtask

    // One host access, checked byte cycle by byte cycle.
    task automatic acc(input bit w, input int sz, input logic [7:0] a,
                       input logic [31:0] wd, input string tag);
        int n, first, rb;
        bit er;
        logic [31:0] exp;
        n = (sz == 0) ? 1 : ((sz == 1) ? 2 : 4);
        first = (w && n == 4 && a[3:0] == 4'd12) ? 2 : 0;
        exp = 32'd0;
        @(negedge clk);
        req = 1'b1; we = w; size = 2'(sz); addr = a; wdata = wd;
        for (int i = first; i < n; i++) begin
            #1;
            model_byte(w, (int'(a) + i) & 15, int'(wd[8*i +: 8]), rb, er);
            exp[8*i +: 8] = 8'(rb);
            chk(tag, "bad_offset", {31'd0, bad}, {31'd0, er});
            chk(tag, "host_ready", {31'd0, ready}, {31'd0, (i == n - 1)});
            if (!w && i == n - 1) chk(tag, "host_rdata", rdata, exp);
            @(negedge clk);
        end
        req = 1'b0;
    endtask

    task automatic summary();
        $display("  %0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // Reset state
        acc(0, 0, 8'd14, 0, "R2");
        acc(0, 0, 8'd15, 0, "R2");
        acc(0, 1, 8'd0,  0, "R5");
        // Offset 15 write ignored
        acc(1, 0, 8'd15, 32'h5a, "R2");
        acc(0, 2, 8'd12, 0, "R2");
        // 16-bit register halves
        acc(1, 1, 8'd0, 32'hbeef, "R5");
        acc(1, 0, 8'd1, 32'h12, "R5");
        acc(0, 1, 8'd0, 0, "R5");
        acc(1, 1, 8'd4, 32'h7788, "R5");
        // Upper address bits ignored
        acc(1, 0, 8'hf0, 32'h3c, "R1");
        acc(0, 1, 8'ha0, 0, "R1");
        acc(0, 2, 8'd4, 0, "R3");
        // Undefined offsets in bank 0
        acc(1, 0, 8'd2, 32'hff, "R11");
        acc(0, 2, 8'd0, 0, "R11");
        // Bank 1: control clear, general purpose
        acc(1, 0, 8'd14, 32'h1, "R2");
        acc(1, 1, 8'd12, 32'h12ff, "R6");
        acc(0, 1, 8'd12, 0, "R6");
        acc(1, 1, 8'd10, 32'ha55a, "R5");
        acc(1, 1, 8'd0, 32'h0102, "R5");
        acc(0, 2, 8'd8, 0, "R11");
        // 16-bit access crossing offset 13 into the bank register
        acc(1, 1, 8'd13, 32'h0040, "R3");
        acc(0, 1, 8'd14, 0, "R3");
        // Back to bank 1; 32-bit write at 12 touches only 14 and 15
        acc(1, 0, 8'd14, 32'h1, "R2");
        acc(1, 2, 8'd12, 32'h33_02_ab_cd, "R4");
        acc(0, 0, 8'd14, 0, "R4");
        // Bank 2, non-incrementing window on packet 1
        acc(1, 0, 8'd2, 32'h1, "R8");
        acc(1, 1, 8'd6, 32'h0010, "R9");
        acc(1, 2, 8'd8, 32'h44332211, "R9");
        acc(0, 2, 8'd8, 0, "R9");
        acc(0, 1, 8'd10, 0, "R9");
        acc(0, 1, 8'd6, 0, "R9");
        // Pointer high byte masked
        acc(1, 0, 8'd7, 32'hff, "R7");
        acc(0, 0, 8'd7, 0, "R7");
        // Auto-increment across the 11-bit wrap
        acc(1, 1, 8'd6, 32'h47fe, "R10");
        acc(1, 2, 8'd8, 32'hd4c3b2a1, "R10");
        acc(0, 1, 8'd6, 0, "R10");
        acc(1, 1, 8'd6, 32'h47fe, "R10");
        acc(0, 2, 8'd10, 0, "R10");
        acc(0, 1, 8'd6, 0, "R10");
        // Receive-queue head selects the buffer
        rx_head = 2'd2;
        acc(1, 1, 8'd6, 32'h8020, "R8");
        acc(1, 1, 8'd9, 32'h9988, "R8");
        acc(1, 0, 8'd2, 32'h2, "R8");
        acc(1, 1, 8'd6, 32'h0020, "R8");
        acc(0, 2, 8'd8, 0, "R8");
        rx_head = 2'd3;
        acc(1, 1, 8'd6, 32'h8020, "R8");
        acc(0, 1, 8'd9, 0, "R8");
        // Undefined bank-2 offsets; 16-bit access wrapping 15 to 0
        acc(0, 1, 8'd12, 0, "R11");
        acc(1, 0, 8'd3, 32'h77, "R11");
        acc(0, 1, 8'd2, 0, "R11");
        acc(0, 1, 8'd15, 0, "R3");
        // Bank 3 has only the common offsets
        acc(1, 0, 8'd14, 32'h3, "R2");
        acc(0, 2, 8'd0, 0, "R11");
        acc(0, 2, 8'd12, 0, "R11");
        summary();
    end

endmodule